// File: doc/BRIEF.md
# Stereo Biquad Equalizer Chain

This block filters a stereo stream that arrives at twice the audio sample rate. Each strobed left/right pair first goes through an optional DC-blocking high-pass stage. It then passes through a chain of up to eight second-order filter slots per channel. A single multiply-accumulate unit works through the slots one coefficient product per clock: all of the left channel first, then all of the right. When the last slot of the right channel has been handled, the block presents both results together with a one-cycle valid strobe.

Configuration bits decide which slots take part. Slots one to four are free user filters. Slots five to seven either serve as de-emphasis, bass and treble stages, or become extra user filters when the two channels share one coefficient set. Slot eight is a user filter that is only available when no crossover or dual-band compression setting claims it. Coefficients sit in an internal bank with one set per channel, loaded through a simple write port. Each coefficient is a 24-bit signed value with 22 fraction bits, so 1.0 is 0x400000.

Top module: `eq_chain`

## Requirements
- R1: After reset, out_valid, out_l and out_r are all zero.
- R2: With hp_bypass at 0, each channel applies y = x - x_prev + y_prev - (y_prev >>> HP_SHIFT), saturated to 24 bits (HP_SHIFT defaults to 8). With hp_bypass at 1, the sample passes unchanged and the high-pass history is held at zero.
- R3: An active slot computes y = b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2 with coefficients in Q2.22 format. The sum is shifted right by 22 and saturated to the range 0x800000..0x7FFFFF. Coefficient index 0..4 selects b0, b1, b2, a1, a2.
- R4: Slots 1 to 4 of a channel are active unless dsp_bypass is 1 or that channel's bit of eq_bypass (bit 0 left, bit 1 right) is 1.
- R5: With coef_link at 0, slot_en is ignored. Slot 5 is active exactly when deemph_en is 1, and slots 6 and 7 are active exactly when that channel's tone_bypass bit is 0.
- R6: With coef_link at 1, both channels read the channel-0 coefficient bank. Slot 5+k (k = 0..2) is active when slot_en[k] is 1 and the channel's user filters are not bypassed.
- R7: Slot 8 is active only when xo_sel is 0000, drc_dual_en is 0 and the channel's user filters are not bypassed.
- R8: An inactive slot passes its input unchanged and leaves its x1, x2, y1 and y2 history untouched.
- R9: out_valid is a single-cycle pulse issued once per accepted sample, after the last slot of the right channel. A sample_in strobe that arrives while a sample is being processed is ignored.
- R10: A write with coef_we stores coef_data in the bank of coef_ch, at slot coef_slot (0..7 meaning slots 1..8), under coef_idx. A write with coef_idx above 4 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | 1 | Accept in_l/in_r when idle |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| hp_bypass | input | 1 | 1 bypasses the DC-blocking stage |
| dsp_bypass | input | 1 | 1 bypasses user filters on both channels |
| eq_bypass | input | 2 | Per-channel user filter bypass |
| tone_bypass | input | 2 | Per-channel bass/treble bypass |
| deemph_en | input | 1 | Enables the de-emphasis slot |
| coef_link | input | 1 | Share channel-0 coefficients, slots 5-7 become user filters |
| slot_en | input | 3 | Enables for slots 5..7 when linked |
| xo_sel | input | 4 | Crossover selection; nonzero claims slot 8 |
| drc_dual_en | input | 1 | Dual-band compression claims slot 8 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_ch | input | 1 | Bank selected for the write |
| coef_slot | input | 3 | Slot selected for the write |
| coef_idx | input | 3 | Coefficient index selected for the write |
| coef_data | input | 24 | Coefficient value, signed Q2.22 |
| out_valid | output | 1 | Result strobe |
| out_l | output | 24 | Filtered left sample |
| out_r | output | 24 | Filtered right sample |

## Verification
The assertions assume that configuration bits and coefficient writes change only while the engine is idle. They also assume that samples arrive no faster than one frame of processing, which is at most about 80 cycles. The bench changes settings and coefficients only after out_valid has been seen, with the engine idle. The one deliberate overlap is a second sample_in strobe sent during processing, which is there to show that such a strobe is ignored. Expected values come from simple gains per slot, so every result is an exact power-of-two division. State-dependent cases use a one-sample delay and a single feedback term, flushed with zero samples first.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int DW     = 24;
    localparam int CW     = 24;
    localparam int FRAC   = 22;
    localparam int NSLOT  = 8;
    localparam int NTAP   = 5;
    localparam int NCH    = 2;
    localparam int PW     = DW + CW;
    localparam int AW     = PW + 4;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int TAP_W  = 3;

    typedef enum logic {PH_IDLE, PH_RUN} phase_t;

    typedef struct packed {
        phase_t                               phase;
        logic                                 ch;
        logic [SLOT_W-1:0]                    slot;
        logic [TAP_W-1:0]                     tap;
        logic signed [AW-1:0]                 acc;
        logic signed [DW-1:0]                 cur;
        logic signed [DW-1:0]                 hold_r;
        logic signed [DW-1:0]                 res_l;
        logic signed [DW-1:0]                 out_l;
        logic signed [DW-1:0]                 out_r;
        logic                                 valid;
        logic [NCH-1:0][DW-1:0]               hx1;
        logic [NCH-1:0][DW-1:0]               hy1;
        logic [NCH-1:0][NSLOT-1:0][DW-1:0]    x1;
        logic [NCH-1:0][NSLOT-1:0][DW-1:0]    x2;
        logic [NCH-1:0][NSLOT-1:0][DW-1:0]    y1;
        logic [NCH-1:0][NSLOT-1:0][DW-1:0]    y2;
    } eng_t;

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [AW-1:0] v);
        logic signed [AW-1:0] hi;
        logic signed [AW-1:0] lo;
        hi = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
        if (v > hi)      return {1'b0, {(DW-1){1'b1}}};
        else if (v < lo) return {1'b1, {(DW-1){1'b0}}};
        else             return v[DW-1:0];
    endfunction
endpackage

// File: rtl/eq_slot_plan.sv
module eq_slot_plan
    import eq_pkg::*;
(
    input  logic             link,
    input  logic [2:0]       slot_en,
    input  logic             deemph_en,
    input  logic             tone_bypass,
    input  logic             user_bypass,
    input  logic [3:0]       xo_sel,
    input  logic             drc_dual,
    output logic [NSLOT-1:0] active
);
    logic user_on;

    always_comb begin
        user_on = !user_bypass;
        active  = '0;
        for (int i = 0; i < 4; i++) active[i] = user_on;
        if (link) begin
            for (int k = 0; k < 3; k++) active[4+k] = slot_en[k] && user_on;
        end else begin
            active[4] = deemph_en;
            active[5] = !tone_bypass;
            active[6] = !tone_bypass;
        end
        active[7] = user_on && (xo_sel == 4'd0) && !drc_dual;
    end
endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank
    import eq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 wch,
    input  logic [SLOT_W-1:0]    wslot,
    input  logic [TAP_W-1:0]     widx,
    input  logic signed [CW-1:0] wdata,
    input  logic                 link,
    input  logic                 rch,
    input  logic [SLOT_W-1:0]    rslot,
    input  logic [TAP_W-1:0]     ridx,
    output logic signed [CW-1:0] rdata
);
    logic [NCH-1:0][NSLOT-1:0][NTAP-1:0][CW-1:0] mem_d, mem_q;
    logic bank_sel;

    always_comb begin
        mem_d = mem_q;
        if (we && (widx < TAP_W'(NTAP))) mem_d[wch][wslot][widx] = wdata;
        bank_sel = link ? 1'b0 : rch;
        rdata    = $signed(mem_q[bank_sel][rslot][ridx]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (widx < TAP_W'(NTAP))) |=> (mem_q[$past(wch)][$past(wslot)][$past(widx)] == $past(wdata)));
endmodule

// File: rtl/eq_chain.sv
module eq_chain
    import eq_pkg::*;
#(
    parameter int HP_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_in,
    input  logic [23:0]   in_l,
    input  logic [23:0]   in_r,
    input  logic          hp_bypass,
    input  logic          dsp_bypass,
    input  logic [1:0]    eq_bypass,
    input  logic [1:0]    tone_bypass,
    input  logic          deemph_en,
    input  logic          coef_link,
    input  logic [2:0]    slot_en,
    input  logic [3:0]    xo_sel,
    input  logic          drc_dual_en,
    input  logic          coef_we,
    input  logic          coef_ch,
    input  logic [2:0]    coef_slot,
    input  logic [2:0]    coef_idx,
    input  logic [23:0]   coef_data,
    output logic          out_valid,
    output logic [23:0]   out_l,
    output logic [23:0]   out_r
);
    eng_t st_d, st_q;

    logic [NCH-1:0][NSLOT-1:0] act_map;
    logic                      act_now;
    logic signed [CW-1:0]      coef;
    logic signed [DW-1:0]      opnd;
    logic signed [PW-1:0]      prod;
    logic signed [AW-1:0]      acc_nx;
    logic signed [DW-1:0]      y_new;
    logic signed [DW-1:0]      result;
    logic signed [DW-1:0]      hp_l, hp_r;
    logic                      fin;

    for (genvar g = 0; g < NCH; g++) begin : g_plan
        eq_slot_plan u_plan (
            .link        (coef_link),
            .slot_en     (slot_en),
            .deemph_en   (deemph_en),
            .tone_bypass (tone_bypass[g]),
            .user_bypass (dsp_bypass | eq_bypass[g]),
            .xo_sel      (xo_sel),
            .drc_dual    (drc_dual_en),
            .active      (act_map[g])
        );
    end

    eq_coef_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .wch   (coef_ch),
        .wslot (coef_slot),
        .widx  (coef_idx),
        .wdata (coef_data),
        .link  (coef_link),
        .rch   (st_q.ch),
        .rslot (st_q.slot),
        .ridx  (st_q.tap),
        .rdata (coef)
    );

    function automatic logic signed [DW-1:0] hp_step(input logic signed [DW-1:0] x,
                                                     input logic signed [DW-1:0] px,
                                                     input logic signed [DW-1:0] py);
        logic signed [AW-1:0] s;
        s = AW'(x) - AW'(px) + AW'(py) - AW'(py >>> HP_SHIFT);
        return sat_dw(s);
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        act_now    = act_map[st_q.ch][st_q.slot];
        hp_l       = hp_step($signed(in_l), $signed(st_q.hx1[0]), $signed(st_q.hy1[0]));
        hp_r       = hp_step($signed(in_r), $signed(st_q.hx1[1]), $signed(st_q.hy1[1]));
        case (st_q.tap)
            3'd0:    opnd = st_q.cur;
            3'd1:    opnd = $signed(st_q.x1[st_q.ch][st_q.slot]);
            3'd2:    opnd = $signed(st_q.x2[st_q.ch][st_q.slot]);
            3'd3:    opnd = $signed(st_q.y1[st_q.ch][st_q.slot]);
            default: opnd = $signed(st_q.y2[st_q.ch][st_q.slot]);
        endcase
        prod   = coef * opnd;
        acc_nx = (st_q.tap >= 3'd3) ? st_q.acc - AW'(prod) : st_q.acc + AW'(prod);
        y_new  = sat_dw(acc_nx >>> FRAC);
        fin    = 1'b0;
        result = st_q.cur;

        if (st_q.phase == PH_IDLE) begin
            if (sample_in) begin
                st_d.phase = PH_RUN;
                st_d.ch    = 1'b0;
                st_d.slot  = '0;
                st_d.tap   = '0;
                st_d.acc   = '0;
                if (hp_bypass) begin
                    st_d.cur    = $signed(in_l);
                    st_d.hold_r = $signed(in_r);
                    st_d.hx1    = '0;
                    st_d.hy1    = '0;
                end else begin
                    st_d.cur    = hp_l;
                    st_d.hold_r = hp_r;
                    st_d.hx1[0] = in_l;
                    st_d.hx1[1] = in_r;
                    st_d.hy1[0] = hp_l;
                    st_d.hy1[1] = hp_r;
                end
            end
        end else begin
            if (!act_now) begin
                fin = 1'b1;
            end else if (st_q.tap == 3'(NTAP - 1)) begin
                fin    = 1'b1;
                result = y_new;
                st_d.acc = '0;
                st_d.tap = '0;
                st_d.x2[st_q.ch][st_q.slot] = st_q.x1[st_q.ch][st_q.slot];
                st_d.x1[st_q.ch][st_q.slot] = st_q.cur;
                st_d.y2[st_q.ch][st_q.slot] = st_q.y1[st_q.ch][st_q.slot];
                st_d.y1[st_q.ch][st_q.slot] = y_new;
            end else begin
                st_d.acc = acc_nx;
                st_d.tap = st_q.tap + 3'd1;
            end
            if (fin) begin
                st_d.cur = result;
                if (st_q.slot == SLOT_W'(NSLOT - 1)) begin
                    st_d.slot = '0;
                    if (!st_q.ch) begin
                        st_d.res_l = result;
                        st_d.ch    = 1'b1;
                        st_d.cur   = st_q.hold_r;
                    end else begin
                        st_d.out_l = st_q.res_l;
                        st_d.out_r = result;
                        st_d.valid = 1'b1;
                        st_d.ch    = 1'b0;
                        st_d.phase = PH_IDLE;
                    end
                end else begin
                    st_d.slot = st_q.slot + SLOT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_l     = st_q.out_l;
    assign out_r     = st_q.out_r;

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r9_valid_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (st_q.phase == PH_IDLE && $past(st_q.phase == PH_RUN)));
    a_r8_skip_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && !act_now) |=>
            ($stable(st_q.x1) && $stable(st_q.x2) && $stable(st_q.y1) && $stable(st_q.y2)));
    a_r2_bypass_clears_hp: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && sample_in && hp_bypass) |=> (st_q.hx1 == '0 && st_q.hy1 == '0));
endmodule

// File: tb/eq_chain_bench.sv
module eq_chain_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_in = 1'b0;
    logic [23:0] in_l = '0, in_r = '0;
    logic hp_bypass = 1'b1, dsp_bypass = 1'b0, deemph_en = 1'b0, coef_link = 1'b0, drc_dual_en = 1'b0;
    logic [1:0] eq_bypass = '0, tone_bypass = '0;
    logic [2:0] slot_en = '0;
    logic [3:0] xo_sel = '0;
    logic coef_we = 1'b0, coef_ch = 1'b0;
    logic [2:0] coef_slot = '0, coef_idx = '0;
    logic [23:0] coef_data = '0;
    logic out_valid;
    logic [23:0] out_l, out_r;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eq_chain u_eq_chain (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .in_l(in_l), .in_r(in_r),
        .hp_bypass(hp_bypass), .dsp_bypass(dsp_bypass), .eq_bypass(eq_bypass),
        .tone_bypass(tone_bypass), .deemph_en(deemph_en), .coef_link(coef_link),
        .slot_en(slot_en), .xo_sel(xo_sel), .drc_dual_en(drc_dual_en),
        .coef_we(coef_we), .coef_ch(coef_ch), .coef_slot(coef_slot), .coef_idx(coef_idx),
        .coef_data(coef_data), .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_coef(input int ch, input int slot, input int idx, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_ch = ch[0]; coef_slot = slot[2:0]; coef_idx = idx[2:0];
        coef_data = val[23:0];
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic set_gain(input int ch, input int slot, input int g);
        for (int t = 0; t < 5; t++) wr_coef(ch, slot, t, (t == 0) ? g : 0);
    endtask

    task automatic frame(input int l, input int r, output int ol, output int orr);
        bit got;
        got = 0;
        @(negedge clk);
        in_l = l[23:0]; in_r = r[23:0]; sample_in = 1'b1;
        @(negedge clk);
        sample_in = 1'b0;
        for (int c = 0; c < 400 && !got; c++) begin
            if (out_valid) got = 1;
            else @(negedge clk);
        end
        if (!got) check("R9 no valid", 0, 1);
        ol  = int'($signed(out_l));
        orr = int'($signed(out_r));
    endtask

    task automatic t_reset();
        check("R1 valid", int'(out_valid), 0);
        check("R1 out_l", int'($signed(out_l)), 0);
        check("R1 out_r", int'($signed(out_r)), 0);
    endtask

    task automatic t_default();
        int a, b;
        frame(128000, 128000, a, b);
        check("R4 R10 default L 7 slots", a, 1000);
        check("R10 bank1 R unity", b, 128000);
        frame(-256000, -256000, a, b);
        check("R7 default L neg", a, -2000);
        check("R7 default R neg", b, -256000);
    endtask

    task automatic t_user_bypass();
        int a, b;
        eq_bypass = 2'b01;
        frame(128000, 128000, a, b);
        check("R4 eq_bypass L", a, 32000);
        check("R4 eq_bypass R untouched", b, 128000);
        eq_bypass = 2'b00; dsp_bypass = 1'b1;
        frame(128000, 128000, a, b);
        check("R4 dsp_bypass L", a, 32000);
        dsp_bypass = 1'b0;
    endtask

    task automatic t_roles();
        int a, b;
        deemph_en = 1'b1;
        frame(256000, 0, a, b);
        check("R5 deemph on", a, 1000);
        deemph_en = 1'b0; tone_bypass = 2'b01;
        frame(128000, 0, a, b);
        check("R5 tone bypass", a, 4000);
        tone_bypass = 2'b00; slot_en = 3'b111;
        frame(128000, 0, a, b);
        check("R5 slot_en ignored unlinked", a, 1000);
        slot_en = 3'b000;
    endtask

    task automatic t_link();
        int a, b;
        coef_link = 1'b1; slot_en = 3'b010;
        frame(128000, 128000, a, b);
        check("R6 linked L", a, 2000);
        check("R6 linked R uses bank0", b, 2000);
        slot_en = 3'b111;
        frame(256000, 256000, a, b);
        check("R6 linked all slots R", b, 1000);
        eq_bypass = 2'b01;
        frame(256000, 256000, a, b);
        check("R6 linked user bypass L", a, 256000);
        eq_bypass = 2'b00; slot_en = 3'b000; coef_link = 1'b0;
    endtask

    task automatic t_slot8();
        int a, b;
        xo_sel = 4'd3;
        frame(128000, 0, a, b);
        check("R7 xo claims slot8", a, 2000);
        xo_sel = 4'd0; drc_dual_en = 1'b1;
        frame(128000, 0, a, b);
        check("R7 drc claims slot8", a, 2000);
        drc_dual_en = 1'b0;
    endtask

    task automatic t_bad_idx();
        int a, b;
        wr_coef(0, 0, 5, 24'h123456);
        wr_coef(0, 0, 7, 24'h654321);
        frame(128000, 0, a, b);
        check("R10 idx above 4 ignored", a, 1000);
    endtask

    task automatic t_state();
        int a, b;
        for (int s = 0; s < 8; s++) set_gain(0, s, 24'h400000);
        tone_bypass = 2'b01; xo_sel = 4'd1;
        frame(0, 0, a, b);
        wr_coef(0, 0, 0, 0);
        wr_coef(0, 0, 1, 24'h400000);
        frame(5000, 0, a, b);
        check("R3 delay first", a, 0);
        frame(7000, 0, a, b);
        check("R3 delay second", a, 5000);
        eq_bypass = 2'b01;
        frame(9000, 0, a, b);
        check("R8 bypass passes input", a, 9000);
        eq_bypass = 2'b00;
        frame(0, 0, a, b);
        check("R8 history kept", a, 7000);
        wr_coef(0, 0, 0, 24'h400000);
        wr_coef(0, 0, 1, 0);
        frame(0, 0, a, b);
        wr_coef(0, 0, 3, 24'hE00000);
        frame(4000, 0, a, b);
        check("R3 feedback n0", a, 4000);
        frame(0, 0, a, b);
        check("R3 feedback n1", a, 2000);
        frame(0, 0, a, b);
        check("R3 feedback n2", a, 1000);
        wr_coef(0, 0, 3, 0);
        wr_coef(0, 0, 0, 24'h7FFFFF);
        frame(24'h600000, 0, a, b);
        check("R3 saturate high", a, 8388607);
        frame(-6291456, 0, a, b);
        check("R3 saturate low", a, -8388608);
        wr_coef(0, 0, 0, 24'h400000);
    endtask

    task automatic t_hpf();
        int a, b;
        eq_bypass = 2'b01; hp_bypass = 1'b0;
        frame(25600, 0, a, b);
        check("R2 hp first", a, 25600);
        frame(25600, 0, a, b);
        check("R2 hp second", a, 25500);
        frame(25600, 0, a, b);
        check("R2 hp third", a, 25401);
        hp_bypass = 1'b1;
        frame(25600, 0, a, b);
        check("R2 hp bypassed", a, 25600);
    endtask

    task automatic t_busy();
        int nvalid;
        nvalid = 0;
        @(negedge clk);
        in_l = 24'd3000; sample_in = 1'b1;
        @(negedge clk);
        in_l = 24'd6000;
        @(negedge clk);
        sample_in = 1'b0;
        for (int c = 0; c < 300; c++) begin
            if (out_valid) begin
                nvalid++;
                check("R9 value of first sample", int'($signed(out_l)), 3000);
            end
            @(negedge clk);
        end
        check("R9 one valid pulse", nvalid, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        for (int s = 0; s < 8; s++) begin
            set_gain(0, s, 24'h200000);
            set_gain(1, s, 24'h400000);
        end
        t_default();
        t_user_bypass();
        t_roles();
        t_link();
        t_slot8();
        t_bad_idx();
        t_state();
        t_hpf();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule